// File: doc/BRIEF.md
# Doorbell-Driven Command Ring Fetcher

This block is the device-side front end of a host-to-device command queue. Software places fixed-size command entries in a circular buffer in shared memory. It programs the buffer's base address and moves a tail index forward through a small register window, then writes a doorbell register. Nothing is fetched before that doorbell.

Once the doorbell is accepted, the block latches the current tail as its stop point. It then walks the ring from its own head index, reading one whole entry per request over a wide memory read port. It decodes the opcode byte of each entry. A recognised command is handed to an execution unit, and the block waits for that unit's completion pulse. An unrecognised entry is skipped and flagged. In both cases the head index advances, wrapping at the ring size.

The fetch state machine has five states:
- `ST_IDLE`: waits for a pending doorbell. It goes to `ST_ISSUE_READ` when head differs from tail, and otherwise stays put.
- `ST_ISSUE_READ`: holds the request until it is granted, then goes to `ST_WAIT_DATA`.
- `ST_WAIT_DATA`: waits for read data, captures it, then goes to `ST_DISPATCH`.
- `ST_DISPATCH`: a recognised opcode goes to `ST_WAIT_DONE`. An unknown opcode goes back to `ST_ISSUE_READ`, or to `ST_IDLE` on the last entry.
- `ST_WAIT_DONE`: on the completion pulse it goes to `ST_ISSUE_READ`, or to `ST_IDLE` on the last entry.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: After reset, all register reads return 0: status, ring base, head and tail. No memory request and no dispatch are asserted.
- R2: No entry is fetched until the doorbell register (offset 0x00, any write value) is written. A doorbell accepted while head equals tail fetches nothing.
- R3: Each read request uses the address ring_base + head × 32. The request is held with a stable address until granted. The ring base register (offset 0x08) stores the written value with its low 5 bits cleared.
- R4: Reads of the status register at offset 0x04 return busy in bit 0 and the error flag in bit 1. The head register is at offset 0x0C and the tail register at offset 0x10, both returned zero-extended. Busy reads 1 while a drain is in progress and 0 once it ends.
- R5: The opcode is bits [7:0] of an entry. Opcodes 0x01 (compute dispatch) and 0x02 (ray-tracing dispatch) raise exec_valid for exactly one cycle. During that cycle exec_opcode carries the opcode and exec_cmd carries the full entry.
- R6: Head advances by one, modulo RING_ENTRIES, after each entry is finished. A drain that crosses the end of the ring continues at index 0.
- R7: An entry with any other opcode is not dispatched and its head slot is consumed. The entry sets the status error bit, which stays set until the host writes status with bit 1 set.
- R8: Writes to the ring base register are ignored while the block is busy.
- R9: Writes to the head register have no effect.
- R10: A drain stops at the tail value captured when the doorbell was accepted. A later tail write without a doorbell fetches nothing more.
- R11: A doorbell written while busy is remembered. After the current drain ends, head is compared with the tail again, and any new entries are drained.
- R12: No new read request is issued between a dispatch and the matching exec_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_rd_req | output | 1 | Entry read request, held until granted |
| mem_rd_addr | output | ADDR_W | Byte address of the requested entry |
| mem_rd_gnt | input | 1 | Memory accepts the request |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | ENTRY_BYTES×8 | One full entry |
| exec_valid | output | 1 | One-cycle command dispatch |
| exec_opcode | output | 8 | Opcode of the dispatched entry |
| exec_cmd | output | ENTRY_BYTES×8 | Dispatched entry |
| exec_done | input | 1 | Execution unit finished the current command |

## Verification
The bench builds the block with RING_ENTRIES set to 8, keeping a 32-bit address and 32-byte entries. With that ring size, head wrap, a drain that crosses index 0, and a drain stopped short of a moved tail all take a handful of entries. Memory answers three cycles after a grant and the execution unit completes four cycles after a dispatch. Each entry therefore spans several cycles, so register writes issued mid-drain reliably land while busy is set.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    localparam int REG_AW = 5;
    localparam int REG_DW = 32;
    localparam int OPC_W  = 8;

    localparam logic [REG_AW-1:0] OFS_DOORBELL  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_STATUS    = 5'h04;
    localparam logic [REG_AW-1:0] OFS_RING_BASE = 5'h08;
    localparam logic [REG_AW-1:0] OFS_HEAD      = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_TAIL      = 5'h10;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;

    localparam int NUM_KNOWN_OPS = 2;
    localparam logic [OPC_W-1:0] KNOWN_OPCODES [NUM_KNOWN_OPS] = '{8'h01, 8'h02};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_READ,
        ST_WAIT_DATA,
        ST_DISPATCH,
        ST_WAIT_DONE
    } fetch_state_t;

endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int RING_ENTRIES = 256,
    parameter int ENTRY_BYTES  = 32,
    localparam int IDX_W       = $clog2(RING_ENTRIES),
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    input  logic              busy,
    input  logic [IDX_W-1:0]  head,
    input  logic              err_set,
    input  logic              db_take,
    output logic [ADDR_W-1:0] ring_base,
    output logic [IDX_W-1:0]  tail,
    output logic              db_pend,
    output logic              err
);

    logic base_q_wr, tail_wr, db_wr, err_clr;
    logic unused_wdata;

    assign base_q_wr    = wr_en && (addr == OFS_RING_BASE) && !busy;
    assign tail_wr      = wr_en && (addr == OFS_TAIL);
    assign db_wr        = wr_en && (addr == OFS_DOORBELL);
    assign err_clr      = wr_en && (addr == OFS_STATUS) && wdata[STAT_ERR_BIT];
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_base <= '0;
            tail      <= '0;
            db_pend   <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (base_q_wr)
                ring_base <= {wdata[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
            if (tail_wr)
                tail <= wdata[IDX_W-1:0];
            if (db_wr)
                db_pend <= 1'b1;
            else if (db_take)
                db_pend <= 1'b0;
            if (err_set)
                err <= 1'b1;
            else if (err_clr)
                err <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_STATUS: begin
                rdata[STAT_BUSY_BIT] = busy;
                rdata[STAT_ERR_BIT]  = err;
            end
            OFS_RING_BASE: rdata = REG_DW'(ring_base);
            OFS_HEAD:      rdata = REG_DW'(head);
            OFS_TAIL:      rdata = REG_DW'(tail);
            default:       rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmd_ring_decode.sv
module cmd_ring_decode
    import cmd_ring_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             known
);

    logic [NUM_KNOWN_OPS-1:0] hit;

    for (genvar i = 0; i < NUM_KNOWN_OPS; i++) begin : g_match
        assign hit[i] = (opcode == KNOWN_OPCODES[i]);
    end

    assign known = |hit;

endmodule

// File: rtl/cmd_ring_fsm.sv
module cmd_ring_fsm
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int RING_ENTRIES = 256,
    parameter int ENTRY_BYTES  = 32,
    localparam int IDX_W       = $clog2(RING_ENTRIES),
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES),
    localparam int DATA_W      = ENTRY_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              db_pend,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  tail,
    input  logic              mem_rd_gnt,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              op_known,
    input  logic              exec_done,
    output logic              db_take,
    output logic              busy,
    output logic              err_set,
    output logic [IDX_W-1:0]  head,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [DATA_W-1:0] entry,
    output logic              exec_valid
);

    fetch_state_t     state_q, state_d;
    logic [IDX_W-1:0] head_q, stop_q, head_inc;
    logic             head_adv, last_entry;

    if ((1 << IDX_W) == RING_ENTRIES) begin : g_pow2_wrap
        assign head_inc = head_q + 1'b1;
    end else begin : g_mod_wrap
        assign head_inc = (head_q == IDX_W'(RING_ENTRIES - 1)) ? '0 : head_q + 1'b1;
    end

    assign last_entry  = (head_inc == stop_q);
    assign head        = head_q;
    assign busy        = (state_q != ST_IDLE);
    assign mem_rd_addr = ring_base + (ADDR_W'(head_q) << ENTRY_SHIFT);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (db_pend && (head_q != tail)) state_d = ST_ISSUE_READ;
            ST_ISSUE_READ: if (mem_rd_gnt) state_d = ST_WAIT_DATA;
            ST_WAIT_DATA:  if (mem_rd_valid) state_d = ST_DISPATCH;
            ST_DISPATCH: begin
                if (op_known)        state_d = ST_WAIT_DONE;
                else if (last_entry) state_d = ST_IDLE;
                else                 state_d = ST_ISSUE_READ;
            end
            ST_WAIT_DONE: begin
                if (exec_done) state_d = last_entry ? ST_IDLE : ST_ISSUE_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            stop_q <= '0;
            entry  <= '0;
        end else begin
            if (head_adv)
                head_q <= head_inc;
            if ((state_q == ST_IDLE) && db_pend)
                stop_q <= tail;
            if ((state_q == ST_WAIT_DATA) && mem_rd_valid)
                entry <= mem_rd_data;
        end
    end

    // outputs
    always_comb begin
        db_take    = 1'b0;
        mem_rd_req = 1'b0;
        exec_valid = 1'b0;
        err_set    = 1'b0;
        head_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE:       db_take = db_pend;
            ST_ISSUE_READ: mem_rd_req = 1'b1;
            ST_WAIT_DATA:  ;
            ST_DISPATCH: begin
                exec_valid = op_known;
                err_set    = !op_known;
                head_adv   = !op_known;
            end
            ST_WAIT_DONE:  head_adv = exec_done;
            default:       ;
        endcase
    end

endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int RING_ENTRIES = 256,
    parameter int ENTRY_BYTES  = 32,
    localparam int IDX_W       = $clog2(RING_ENTRIES),
    localparam int DATA_W      = ENTRY_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_gnt,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              exec_valid,
    output logic [OPC_W-1:0]  exec_opcode,
    output logic [DATA_W-1:0] exec_cmd,
    input  logic              exec_done
);

    logic              busy_w, err_w, err_set_w, db_pend_w, db_take_w, known_w;
    logic [IDX_W-1:0]  head_w, tail_w;
    logic [ADDR_W-1:0] base_w;
    logic [DATA_W-1:0] entry_w;

    cmd_ring_regs #(
        .ADDR_W(ADDR_W), .RING_ENTRIES(RING_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy_w), .head(head_w), .err_set(err_set_w), .db_take(db_take_w),
        .ring_base(base_w), .tail(tail_w), .db_pend(db_pend_w), .err(err_w)
    );

    cmd_ring_decode u_dec (
        .opcode(entry_w[OPC_W-1:0]),
        .known(known_w)
    );

    cmd_ring_fsm #(
        .ADDR_W(ADDR_W), .RING_ENTRIES(RING_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .db_pend(db_pend_w), .ring_base(base_w), .tail(tail_w),
        .mem_rd_gnt(mem_rd_gnt), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .op_known(known_w), .exec_done(exec_done),
        .db_take(db_take_w), .busy(busy_w), .err_set(err_set_w), .head(head_w),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .entry(entry_w), .exec_valid(exec_valid)
    );

    assign exec_cmd    = entry_w;
    assign exec_opcode = entry_w[OPC_W-1:0];

endmodule

// File: rtl/cmd_ring_fetcher_sva.sv
module cmd_ring_fetcher_sva
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int RING_ENTRIES = 256,
    localparam int IDX_W       = $clog2(RING_ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic              err_clr_bit,
    input logic              mem_rd_req,
    input logic              mem_rd_gnt,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              exec_valid,
    input logic              exec_done,
    input logic              busy,
    input logic [IDX_W-1:0]  head,
    input logic [ADDR_W-1:0] ring_base,
    input logic              err
);

    logic exec_open;

    always_ff @(posedge clk) begin
        if (!rst_n)          exec_open <= 1'b0;
        else if (exec_valid) exec_open <= 1'b1;
        else if (exec_done)  exec_open <= 1'b0;
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_req); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_gnt) |=> (mem_rd_req && $stable(mem_rd_addr))); // R3

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[4:0] == 5'd0)); // R3

    AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> !exec_valid); // R5

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head) |-> (($past(head) == IDX_W'(RING_ENTRIES - 1)) ? (head == '0)
                                                                       : (head == $past(head) + 1'b1))); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr_en && (reg_addr == OFS_STATUS) && err_clr_bit)) |=> err); // R7

    AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ring_base)); // R8

    AST_WAIT_FOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_open |-> !mem_rd_req); // R12

endmodule

bind cmd_ring_fetcher cmd_ring_fetcher_sva #(
    .ADDR_W(ADDR_W), .RING_ENTRIES(RING_ENTRIES)
) u_sva (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .err_clr_bit(reg_wdata[1]),
    .mem_rd_req(mem_rd_req), .mem_rd_gnt(mem_rd_gnt), .mem_rd_addr(mem_rd_addr),
    .exec_valid(exec_valid), .exec_done(exec_done),
    .busy(busy_w), .head(head_w), .ring_base(base_w), .err(err_w)
);

// File: tb/cmd_ring_fetcher_tb_top.sv
module cmd_ring_fetcher_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RING       = 8;
    localparam int AW         = 32;
    localparam int DW         = 256;
    localparam int MEM_LAT    = 3;
    localparam int EXEC_LAT   = 4;
    localparam logic [31:0] BASE_A = 32'h4000_0000;
    localparam logic [31:0] BASE_B = 32'h5000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_gnt = 1'b0;
    logic          mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic          exec_valid;
    logic [7:0]    exec_opcode;
    logic [DW-1:0] exec_cmd;
    logic          exec_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_ring_fetcher #(.ADDR_W(AW), .RING_ENTRIES(RING), .ENTRY_BYTES(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_gnt(mem_rd_gnt),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .exec_valid(exec_valid), .exec_opcode(exec_opcode), .exec_cmd(exec_cmd),
        .exec_done(exec_done)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  op_tbl [RING];
    logic [31:0] cur_base = BASE_A;
    logic [31:0] req_log  [32];
    logic [31:0] exe_log  [32];
    logic [7:0]  opc_log  [32];
    int req_cnt = 0, exe_cnt = 0, mem_cnt = 0, done_cnt = 0, overlap_viol = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [DW-1:0] make_entry(input logic [31:0] a);
        logic [DW-1:0] e;
        int idx;
        idx = int'((a - cur_base) >> 5) % RING;
        e = {8{a}};
        e[7:0] = op_tbl[idx];
        return e;
    endfunction

    // memory and execution-unit models, driven away from the active edge
    always @(negedge clk) begin
        mem_rd_gnt   = 1'b0;
        mem_rd_valid = 1'b0;
        exec_done    = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = make_entry(pend_addr);
            end
        end else if (mem_rd_req && rst_n) begin
            mem_rd_gnt = 1'b1;
            pend_addr  = mem_rd_addr;
            if (req_cnt < 32) req_log[req_cnt] = mem_rd_addr;
            req_cnt++;
            mem_cnt = MEM_LAT;
            if (done_cnt > 0) overlap_viol++;
        end
        if (done_cnt > 0) begin
            done_cnt--;
            if (done_cnt == 0) exec_done = 1'b1;
        end else if (exec_valid && rst_n) begin
            if (exe_cnt < 32) begin
                exe_log[exe_cnt] = exec_cmd[DW-1:DW-32];
                opc_log[exe_cnt] = exec_opcode;
            end
            exe_cnt++;
            done_cnt = EXEC_LAT;
        end
    end

    task automatic check_eq(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_logs();
        req_cnt = 0; exe_cnt = 0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int guard = 0;
        logic [31:0] s;
        while (quiet < 3 && guard < 5000) begin
            reg_rd(5'h04, s);
            if (s[0] == 1'b0) quiet++; else quiet = 0;
            guard++;
        end
    endtask

    task automatic check_seq(input string tag, input int first, input int n);
        for (int k = 0; k < n; k++)
            check_eq(tag, longint'(exe_log[k]), longint'(cur_base + 32'((first + k) % RING) * 32));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(5'h04, d); check_eq("R1 status", d, 0);
        reg_rd(5'h08, d); check_eq("R1 base", d, 0);
        reg_rd(5'h0C, d); check_eq("R1 head", d, 0);
        reg_rd(5'h10, d); check_eq("R1 tail", d, 0);
        check_eq("R1 req", mem_rd_req, 0);
        check_eq("R1 exec", exec_valid, 0);
    endtask

    task automatic t_no_doorbell();
        logic [31:0] d;
        clear_logs();
        reg_wr(5'h08, 32'h4000_001F);
        reg_rd(5'h08, d); check_eq("R3 base low bits cleared", d, BASE_A);
        reg_wr(5'h10, 32'd3);
        repeat (20) @(negedge clk);
        check_eq("R2 no fetch before doorbell", req_cnt, 0);
        reg_rd(5'h0C, d); check_eq("R2 head unchanged", d, 0);
    endtask

    task automatic t_basic_drain();
        logic [31:0] d;
        clear_logs();
        reg_wr(5'h00, 32'h0);
        repeat (2) @(negedge clk);
        reg_rd(5'h04, d); check_eq("R4 busy during drain", d[0], 1);
        wait_idle();
        check_eq("R5 dispatch count", exe_cnt, 3);
        check_seq("R3 entry address", 0, 3);
        check_eq("R3 request count", req_cnt, 3);
        check_eq("R3 first request address", req_log[0], BASE_A);
        check_eq("R5 opcode 0", opc_log[0], 8'h02);
        check_eq("R5 opcode 2", opc_log[2], 8'h01);
        reg_rd(5'h0C, d); check_eq("R6 head after drain", d, 3);
        reg_rd(5'h04, d); check_eq("R4 idle after drain", d, 0);
    endtask

    task automatic t_locks();
        logic [31:0] d;
        clear_logs();
        reg_wr(5'h10, 32'd5);
        reg_wr(5'h00, 32'h1);
        repeat (2) @(negedge clk);
        reg_wr(5'h08, BASE_B);
        reg_wr(5'h0C, 32'd7);
        wait_idle();
        reg_rd(5'h08, d); check_eq("R8 base write ignored while busy", d, BASE_A);
        check_seq("R8 drain kept old base", 3, 2);
        reg_wr(5'h0C, 32'd2);
        reg_rd(5'h0C, d); check_eq("R9 head read-only", d, 5);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        clear_logs();
        reg_wr(5'h10, 32'd2);
        reg_wr(5'h00, 32'h0);
        wait_idle();
        check_eq("R6 wrap dispatch count", exe_cnt, 5);
        check_seq("R6 wrap addresses", 5, 5);
        reg_rd(5'h0C, d); check_eq("R6 head after wrap", d, 2);
    endtask

    task automatic t_unknown();
        logic [31:0] d;
        clear_logs();
        op_tbl[3] = 8'h55;
        reg_wr(5'h10, 32'd5);
        reg_wr(5'h00, 32'h0);
        wait_idle();
        check_eq("R7 requests incl skipped", req_cnt, 3);
        check_eq("R7 dispatched", exe_cnt, 2);
        check_eq("R7 skipped entry not sent", exe_log[1], cur_base + 32'd4 * 32);
        reg_rd(5'h04, d); check_eq("R7 error set", d, 32'h2);
        reg_rd(5'h0C, d); check_eq("R7 head past skipped", d, 5);
        op_tbl[3] = 8'h02;
        reg_wr(5'h10, 32'd6);
        reg_wr(5'h00, 32'h0);
        wait_idle();
        reg_rd(5'h04, d); check_eq("R7 error sticky", d, 32'h2);
        reg_wr(5'h04, 32'h2);
        reg_rd(5'h04, d); check_eq("R7 error cleared", d, 0);
    endtask

    task automatic t_snapshot();
        logic [31:0] d;
        clear_logs();
        reg_wr(5'h10, 32'd0);
        reg_wr(5'h00, 32'h0);
        repeat (2) @(negedge clk);
        reg_wr(5'h10, 32'd3);
        wait_idle();
        repeat (20) @(negedge clk);
        check_eq("R10 stop at captured tail", exe_cnt, 2);
        reg_rd(5'h0C, d); check_eq("R10 head", d, 0);
    endtask

    task automatic t_latched();
        logic [31:0] d;
        clear_logs();
        reg_wr(5'h00, 32'h0);
        repeat (2) @(negedge clk);
        reg_wr(5'h10, 32'd5);
        reg_wr(5'h00, 32'h0);
        wait_idle();
        check_eq("R11 latched doorbell drains more", exe_cnt, 5);
        check_seq("R11 order", 0, 5);
        reg_rd(5'h0C, d); check_eq("R11 head", d, 5);
    endtask

    task automatic t_empty_doorbell();
        logic [31:0] d;
        clear_logs();
        reg_wr(5'h00, 32'h0);
        repeat (10) @(negedge clk);
        check_eq("R2 empty ring no fetch", req_cnt, 0);
        reg_rd(5'h04, d); check_eq("R2 empty ring idle", d, 0);
        check_eq("R12 no read while command open", overlap_viol, 0);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        for (int i = 0; i < RING; i++) op_tbl[i] = 8'h02;
        op_tbl[2] = 8'h01;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_doorbell();
        t_basic_drain();
        t_locks();
        t_wrap();
        t_unknown();
        t_snapshot();
        t_latched();
        t_empty_doorbell();
        report();
    end

endmodule